// File: doc/BRIEF.md
# Synthesizer Programming Interface

This block is the control front end of an integer frequency synthesizer. It takes divider settings through one of three load paths: a serial shift port, an 8-bit parallel port with three section strobes, or dedicated direct pins. Two mode pins choose the path. Serial and parallel writes fill a 20-bit staging word. A transfer strobe copies that word into a 20-bit hold word. A live select pin then decides which of the two words drives the reference divider (6 bits), the main divider (9 bits), the swallow count (4 bits) and the prescaler enable. Software can prepare the next channel in the staging word and switch to it with one pin.

An 8-bit option register can be loaded in parallel with its own strobe. It can also be shifted in serially and is then committed when its enable falls. When the option-enable pin is low, the option register drives power-down, immediate-load, monitor-disable and data-out source controls.

All pins are asynchronous to the system clock. They pass through two-flop synchronizers, and each strobe edge is detected once in the clock domain. All outputs are registered.

Top module: `synth_prog_if`

## Requirements
- R1: With mode_direct high, the outputs follow the direct pins: cnt_r = {2'b00, dir_r}, cnt_m = {2'b00, dir_m}, cnt_a = dir_a, cnt_pre_en = dir_pre_en. The two upper bits of the reference and main counts are always zero in this mode.
- R2: In serial mode (mode_direct low, mode_serial high), with ser_wr and enh_wr both low, each ser_clk rising edge shifts ser_dat into bit 0 of the staging word. The first bit sent ends in bit 19. Word layout: [19:18] = R[5:4], [17:16] = M[8:7], [15] = prescaler enable, [14:8] = M[6:0], [7:4] = R[3:0], [3:0] = A.
- R3: In serial mode, ser_clk edges do not shift while ser_wr is high. A rising edge of ser_wr copies the staging word into the hold word.
- R4: In parallel mode (both mode pins low), a rising par_wr_m2 loads par_d[3:0] into word [19:16]. A rising par_wr_m1 loads par_d into word [15:8]. A rising par_wr_ra loads par_d into word [7:0].
- R5: A rising hop_wr copies the staging word into the hold word in serial and in parallel mode. If a staging write lands in the same cycle, the hold word receives the staging contents from before that write.
- R6: The counter outputs decode the staging word when the select pin is high and the hold word when it is low. The select pin is fsel_ser in serial mode and fsel_par in parallel mode.
- R7: In serial mode with enh_wr high and ser_wr low, ser_clk rising edges shift ser_dat into an 8-bit option shifter, first bit to bit 7. The shifter reaches the option register only on the falling edge of enh_wr. Until then the controls keep their old values.
- R8: In parallel mode, a rising enh_wr loads par_d into the option register.
- R9: While enh_n is low, option bit 3 drives pwr_down, bit 4 drives imm_load and bit 7 drives mon_off. While enh_n is high, all option controls are zero. Bits 0 to 2 have no effect.
- R10: dout_sel is 2'b01 (modulus select) when option bit 5 is set, 2'b10 (raw prescaler) when only bit 6 is set, and 2'b00 (driven low) otherwise or while enh_n is high.
- R11: A strobe held high performs exactly one load. Data that changes while the strobe stays high is not taken.
- R12: Parallel section strobes have no effect on the staging word in serial mode.
- R13: After reset, both words and the option register are zero. All outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_direct | input | 1 | High selects direct pin mode |
| mode_serial | input | 1 | With mode_direct low: high serial, low parallel |
| ser_clk | input | 1 | Serial shift clock (edge sampled) |
| ser_dat | input | 1 | Serial data |
| ser_wr | input | 1 | Serial shift inhibit / transfer strobe |
| enh_wr | input | 1 | Option register shift enable / write strobe |
| par_d | input | 8 | Parallel data bus |
| par_wr_m1 | input | 1 | Parallel strobe for word [15:8] |
| par_wr_m2 | input | 1 | Parallel strobe for word [19:16] |
| par_wr_ra | input | 1 | Parallel strobe for word [7:0] |
| hop_wr | input | 1 | Staging-to-hold transfer strobe |
| fsel_ser | input | 1 | Word select in serial mode (1 = staging) |
| fsel_par | input | 1 | Word select in parallel mode (1 = staging) |
| enh_n | input | 1 | Low enables option register controls |
| dir_r | input | 4 | Direct reference count, low bits |
| dir_m | input | 7 | Direct main count, low bits |
| dir_a | input | 4 | Direct swallow count |
| dir_pre_en | input | 1 | Direct prescaler enable |
| cnt_r | output | 6 | Active reference divider value |
| cnt_m | output | 9 | Active main divider value |
| cnt_a | output | 4 | Active swallow count |
| cnt_pre_en | output | 1 | Active prescaler enable |
| pwr_down | output | 1 | Power-down control |
| imm_load | output | 1 | Immediate counter load control |
| mon_off | output | 1 | Divider monitor outputs disabled |
| dout_sel | output | 2 | Data-out source code |

## Verification
A staging-word write and a staging-to-hold transfer can fall in the same clock cycle. The bench provokes this by raising par_wr_m1 and hop_wr in the same step. Both pass through identical synchronizers, so their internal pulses coincide. The result is judged through the select pin. The hold word must still decode to the staging contents from before the write, and the staging word must show the new byte.

// File: rtl/prog_pkg.sv
package prog_pkg;

    localparam int R_W    = 6;
    localparam int M_W    = 9;
    localparam int A_W    = 4;
    localparam int PD_W   = 8;
    localparam int ENH_W  = 8;
    localparam int HI_W   = 2;
    localparam int R_LO_W = R_W - HI_W;
    localparam int M_LO_W = M_W - HI_W;
    localparam int WORD_W = A_W + R_LO_W + M_LO_W + 1 + 2 * HI_W;
    localparam int RL_POS = A_W;
    localparam int ML_POS = RL_POS + R_LO_W;
    localparam int PRE_POS = ML_POS + M_LO_W;
    localparam int UP_W   = 2 * HI_W;

    // strobe vector positions
    localparam int S_CLK = 0;
    localparam int S_SWR = 1;
    localparam int S_EWR = 2;
    localparam int S_M1  = 3;
    localparam int S_M2  = 4;
    localparam int S_AW  = 5;
    localparam int S_HOP = 6;
    localparam int NSTB  = 7;

    // option register bit positions
    localparam int E_PDN  = 3;
    localparam int E_LOAD = 4;
    localparam int E_MSEL = 5;
    localparam int E_PRES = 6;
    localparam int E_MOFF = 7;

    typedef enum logic [1:0] {
        MODE_PAR = 2'd0,
        MODE_SER = 2'd1,
        MODE_DIR = 2'd2
    } mode_e;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
        logic           pre;
    } cnt_t;

    typedef struct packed {
        logic [WORD_W-1:0] prim;
        logic [WORD_W-1:0] sec;
        logic [ENH_W-1:0]  esr;
        logic [ENH_W-1:0]  ehold;
        logic [NSTB-1:0]   prev;
    } regs_t;

    typedef struct packed {
        cnt_t       cnt;
        logic       pdn;
        logic       load;
        logic       moff;
        logic [1:0] dsel;
    } outs_t;

    function automatic cnt_t unpack_word(input logic [WORD_W-1:0] w);
        cnt_t c;
        c.a   = w[A_W-1:0];
        c.r   = {w[WORD_W-1 -: HI_W], w[RL_POS +: R_LO_W]};
        c.m   = {w[WORD_W-1-HI_W -: HI_W], w[ML_POS +: M_LO_W]};
        c.pre = w[PRE_POS];
        return c;
    endfunction

endpackage

// File: rtl/prog_sync.sv
module prog_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [STAGES-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-2:0], din[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end

        assign dout[i] = sh_q[STAGES-1];
    end

endmodule

// File: rtl/prog_regs.sv
module prog_regs
    import prog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mode_e             mode,
    input  logic [NSTB-1:0]   stb,
    input  logic              sdat,
    input  logic [PD_W-1:0]   pd,
    output logic [WORD_W-1:0] prim,
    output logic [WORD_W-1:0] sec,
    output logic [ENH_W-1:0]  ehold
);

    regs_t           q, d;
    logic [NSTB-1:0] rise, fall;
    logic            ser, par, xfer, shift_en, prim_wr, hold_wr;

    always_comb begin
        rise     = stb & ~q.prev;
        fall     = ~stb & q.prev;
        ser      = (mode == MODE_SER);
        par      = (mode == MODE_PAR);
        xfer     = ((ser || par) && rise[S_HOP]) || (ser && rise[S_SWR]);
        shift_en = ser && rise[S_CLK] && !stb[S_SWR];
        prim_wr  = (shift_en && !stb[S_EWR]) ||
                   (par && (rise[S_M1] || rise[S_M2] || rise[S_AW]));
        hold_wr  = (ser && fall[S_EWR]) || (par && rise[S_EWR]);

        d      = q;
        d.prev = stb;

        // transfer reads the register value, so a same-cycle write is not seen
        if (xfer) d.sec = q.prim;

        if (shift_en) begin
            if (stb[S_EWR]) d.esr  = {q.esr[ENH_W-2:0], sdat};
            else            d.prim = {q.prim[WORD_W-2:0], sdat};
        end

        if (par) begin
            if (rise[S_M2]) d.prim[WORD_W-1 -: UP_W] = pd[UP_W-1:0];
            if (rise[S_M1]) d.prim[PRE_POS -: PD_W]  = pd;
            if (rise[S_AW]) d.prim[PD_W-1:0]         = pd;
        end

        if (hold_wr) d.ehold = ser ? q.esr : pd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign prim  = q.prim;
    assign sec   = q.sec;
    assign ehold = q.ehold;

    a_r5_sec_on_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sec) |-> $past(xfer));

    a_r4_prim_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.prim) |-> $past(prim_wr));

    a_r7_hold_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.ehold) |-> $past(hold_wr));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/prog_enh_dec.sv
module prog_enh_dec
    import prog_pkg::*;
(
    input  logic [ENH_W-1:0] ehold,
    input  logic             enh_n,
    output logic             pdn,
    output logic             load,
    output logic             moff,
    output logic [1:0]       dsel
);

    logic unused_rsv;
    assign unused_rsv = ^ehold[E_PDN-1:0];

    always_comb begin
        pdn  = !enh_n && ehold[E_PDN];
        load = !enh_n && ehold[E_LOAD];
        moff = !enh_n && ehold[E_MOFF];
        dsel = 2'b00;
        if (!enh_n) begin
            if (ehold[E_MSEL])      dsel = 2'b01;
            else if (ehold[E_PRES]) dsel = 2'b10;
        end
    end

endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
    import prog_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_direct,
    input  logic                 mode_serial,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    input  logic                 ser_wr,
    input  logic                 enh_wr,
    input  logic [PD_W-1:0]      par_d,
    input  logic                 par_wr_m1,
    input  logic                 par_wr_m2,
    input  logic                 par_wr_ra,
    input  logic                 hop_wr,
    input  logic                 fsel_ser,
    input  logic                 fsel_par,
    input  logic                 enh_n,
    input  logic [R_LO_W-1:0]    dir_r,
    input  logic [M_LO_W-1:0]    dir_m,
    input  logic [A_W-1:0]       dir_a,
    input  logic                 dir_pre_en,
    output logic [R_W-1:0]       cnt_r,
    output logic [M_W-1:0]       cnt_m,
    output logic [A_W-1:0]       cnt_a,
    output logic                 cnt_pre_en,
    output logic                 pwr_down,
    output logic                 imm_load,
    output logic                 mon_off,
    output logic [1:0]           dout_sel
);

    localparam int DIR_W  = R_LO_W + M_LO_W + A_W + 1;
    localparam int CTL_W  = 5;
    localparam int SYNC_W = NSTB + 1 + PD_W + CTL_W + DIR_W;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic [NSTB-1:0]   s_stb;
    logic              s_sdat, s_bm, s_sm, s_fs, s_fp, s_enh_n, s_dpre;
    logic [PD_W-1:0]   s_pd;
    logic [R_LO_W-1:0] s_dr;
    logic [M_LO_W-1:0] s_dm;
    logic [A_W-1:0]    s_da;

    assign sync_in = {dir_pre_en, dir_a, dir_m, dir_r,
                      enh_n, fsel_par, fsel_ser, mode_serial, mode_direct,
                      par_d, ser_dat,
                      hop_wr, par_wr_ra, par_wr_m2, par_wr_m1, enh_wr, ser_wr, ser_clk};

    prog_sync #(.N(SYNC_W), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sync_in),
        .dout (sync_out)
    );

    assign {s_dpre, s_da, s_dm, s_dr,
            s_enh_n, s_fp, s_fs, s_sm, s_bm,
            s_pd, s_sdat, s_stb} = sync_out;

    mode_e             mode;
    logic [WORD_W-1:0] prim, sec;
    logic [ENH_W-1:0]  ehold;
    logic              e_pdn, e_load, e_moff;
    logic [1:0]        e_dsel;

    assign mode = s_bm ? MODE_DIR : (s_sm ? MODE_SER : MODE_PAR);

    prog_regs u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode),
        .stb  (s_stb),
        .sdat (s_sdat),
        .pd   (s_pd),
        .prim (prim),
        .sec  (sec),
        .ehold(ehold)
    );

    prog_enh_dec u_dec (
        .ehold(ehold),
        .enh_n(s_enh_n),
        .pdn  (e_pdn),
        .load (e_load),
        .moff (e_moff),
        .dsel (e_dsel)
    );

    outs_t o_d, o_q;

    always_comb begin
        o_d = '0;
        unique case (mode)
            MODE_DIR: begin
                o_d.cnt.r   = {{HI_W{1'b0}}, s_dr};
                o_d.cnt.m   = {{HI_W{1'b0}}, s_dm};
                o_d.cnt.a   = s_da;
                o_d.cnt.pre = s_dpre;
            end
            MODE_SER: o_d.cnt = unpack_word(s_fs ? prim : sec);
            default:  o_d.cnt = unpack_word(s_fp ? prim : sec);
        endcase
        o_d.pdn  = e_pdn;
        o_d.load = e_load;
        o_d.moff = e_moff;
        o_d.dsel = e_dsel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign cnt_r      = o_q.cnt.r;
    assign cnt_m      = o_q.cnt.m;
    assign cnt_a      = o_q.cnt.a;
    assign cnt_pre_en = o_q.cnt.pre;
    assign pwr_down   = o_q.pdn;
    assign imm_load   = o_q.load;
    assign mon_off    = o_q.moff;
    assign dout_sel   = o_q.dsel;

    a_r1_direct_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIR) |=> (cnt_r[R_W-1 -: HI_W] == '0 && cnt_m[M_W-1 -: HI_W] == '0));

    a_r9_enh_gated: assert property (@(posedge clk) disable iff (!rst_n)
        s_enh_n |=> (!pwr_down && !imm_load && !mon_off && dout_sel == 2'b00));

    a_r10_dout_code: assert property (@(posedge clk) disable iff (!rst_n)
        dout_sel != 2'b11);

endmodule

// File: tb/synth_prog_if_test.sv
module synth_prog_if_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_direct = 0, mode_serial = 0;
    logic       ser_clk = 0, ser_dat = 0, ser_wr = 0, enh_wr = 0;
    logic [7:0] par_d = 8'h00;
    logic       par_wr_m1 = 0, par_wr_m2 = 0, par_wr_ra = 0, hop_wr = 0;
    logic       fsel_ser = 0, fsel_par = 0, enh_n = 0;
    logic [3:0] dir_r = 0;
    logic [6:0] dir_m = 0;
    logic [3:0] dir_a = 0;
    logic       dir_pre_en = 0;
    logic [5:0] cnt_r;
    logic [8:0] cnt_m;
    logic [3:0] cnt_a;
    logic       cnt_pre_en, pwr_down, imm_load, mon_off;
    logic [1:0] dout_sel;

    always #10 clk = ~clk;

    synth_prog_if uut (
        .clk(clk), .rst_n(rst_n), .mode_direct(mode_direct), .mode_serial(mode_serial),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_wr(ser_wr), .enh_wr(enh_wr),
        .par_d(par_d), .par_wr_m1(par_wr_m1), .par_wr_m2(par_wr_m2), .par_wr_ra(par_wr_ra),
        .hop_wr(hop_wr), .fsel_ser(fsel_ser), .fsel_par(fsel_par), .enh_n(enh_n),
        .dir_r(dir_r), .dir_m(dir_m), .dir_a(dir_a), .dir_pre_en(dir_pre_en),
        .cnt_r(cnt_r), .cnt_m(cnt_m), .cnt_a(cnt_a), .cnt_pre_en(cnt_pre_en),
        .pwr_down(pwr_down), .imm_load(imm_load), .mon_off(mon_off), .dout_sel(dout_sel)
    );

    logic [19:0] obs;
    logic [4:0]  eobs;
    assign obs  = {cnt_r, cnt_m, cnt_a, cnt_pre_en};
    assign eobs = {pwr_down, imm_load, mon_off, dout_sel};

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // {staging word, expected {r,m,a,pre}}
    localparam logic [39:0] VEC [6] = '{
        {20'hFFFFF, 20'hFFFFF},
        {20'h00000, 20'h00000},
        {20'h80000, 20'h80000},
        {20'h08000, 20'h00001},
        {20'h00A5C, 20'h14158},
        {20'h53C96, 20'h6578C}
    };

    // field layout stated in R2
    function automatic logic [19:0] exp_of(input logic [19:0] w);
        return {w[19:18], w[7:4], w[17:16], w[14:8], w[3:0], w[15]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic strobe(input int id);
        case (id)
            0: par_wr_m1 = 1;  1: par_wr_m2 = 1;  2: par_wr_ra = 1;
            3: hop_wr = 1;     4: enh_wr = 1;     5: ser_wr = 1;
            default: ser_clk = 1;
        endcase
        settle();
        par_wr_m1 = 0; par_wr_m2 = 0; par_wr_ra = 0; hop_wr = 0;
        enh_wr = 0; ser_wr = 0; ser_clk = 0;
        settle();
    endtask

    task automatic par_write(input logic [19:0] w);
        par_d = {4'h0, w[19:16]}; strobe(1);
        par_d = w[15:8];          strobe(0);
        par_d = w[7:0];           strobe(2);
    endtask

    task automatic shift(input int n, input logic [19:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            settle();
            ser_clk = 1;
            settle();
            ser_clk = 0;
            settle();
        end
    endtask

    task automatic shift_enh(input logic [7:0] v);
        enh_wr = 1;
        settle();
        shift(8, {12'h000, v});
        enh_wr = 0;
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [19:0] cur, prev_exp, w1, w2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        settle();
        chk("R13 counters after reset", obs, 20'h0);
        chk("R13 options after reset", eobs, 5'h0);

        // vector table, parallel mode
        prev_exp = 20'h0;
        for (int i = 0; i < 6; i++) begin
            par_write(VEC[i][39:20]);
            fsel_par = 1; settle();
            chk("R4 staging after parallel write", obs, VEC[i][19:0]);
            fsel_par = 0; settle();
            chk("R6 hold selected before hop", obs, prev_exp);
            strobe(3);
            chk("R5 hold after hop", obs, VEC[i][19:0]);
            prev_exp = VEC[i][19:0];
        end
        cur = VEC[5][39:20];

        // R11: held strobe loads once
        par_d = 8'h11; par_wr_m1 = 1; settle();
        par_d = 8'h22; settle();
        par_wr_m1 = 0; settle();
        cur[15:8] = 8'h11;
        fsel_par = 1; settle();
        chk("R11 held strobe single load", obs, exp_of(cur));

        // R5: write and hop in the same cycle
        par_d = 8'h7E; par_wr_m1 = 1; hop_wr = 1; settle();
        par_wr_m1 = 0; hop_wr = 0; settle();
        fsel_par = 0; settle();
        chk("R5 same-cycle hop keeps old word", obs, exp_of(cur));
        cur[15:8] = 8'h7E;
        fsel_par = 1; settle();
        chk("R5 same-cycle write reaches staging", obs, exp_of(cur));

        // R8 / R9 parallel options
        par_d = 8'h88; strobe(4);
        chk("R8 parallel option load", eobs, 5'b10100);
        enh_n = 1; settle();
        chk("R9 options gated by enh_n", eobs, 5'b00000);
        enh_n = 0; settle();

        // serial mode
        mode_serial = 1; fsel_ser = 1; settle();
        par_d = 8'hFF; strobe(2);
        chk("R12 parallel strobe ignored in serial", obs, exp_of(cur));

        w1 = 20'hC3A5E;
        shift(20, w1);
        chk("R2 serial shift order", obs, exp_of(w1));

        ser_wr = 1; settle();
        ser_dat = 1; ser_clk = 1; settle();
        ser_clk = 0; settle();
        ser_wr = 0; settle();
        chk("R3 no shift while ser_wr high", obs, exp_of(w1));
        fsel_ser = 0; settle();
        chk("R3 ser_wr rise copies to hold", obs, exp_of(w1));

        w2 = 20'h1F00F;
        fsel_ser = 1;
        shift(20, w2);
        fsel_ser = 0; settle();
        chk("R6 serial select low shows hold", obs, exp_of(w1));
        strobe(3);
        chk("R5 hop in serial mode", obs, exp_of(w2));

        // R7 serial option load, committed on enh_wr fall
        enh_wr = 1; settle();
        shift(8, 20'h00018);
        chk("R7 option unchanged before enh_wr fall", eobs, 5'b10100);
        enh_wr = 0; settle();
        chk("R7 option committed on enh_wr fall", eobs, 5'b11000);

        shift_enh(8'h60);
        chk("R10 modulus select wins", eobs, 5'b00001);
        shift_enh(8'h40);
        chk("R10 prescaler output only", eobs, 5'b00010);
        shift_enh(8'h07);
        chk("R9 reserved bits no effect", eobs, 5'b00000);
        shift_enh(8'h80);
        chk("R9 monitor disable bit", eobs, 5'b00100);

        // R1 direct mode
        mode_direct = 1;
        dir_r = 4'hA; dir_m = 7'h55; dir_a = 4'h3; dir_pre_en = 1; settle();
        chk("R1 direct pins pattern A", obs, {6'h0A, 9'h055, 4'h3, 1'b1});
        dir_r = 4'hF; dir_m = 7'h7F; dir_a = 4'hF; dir_pre_en = 0; settle();
        chk("R1 direct upper bits forced low", obs, {6'h0F, 9'h07F, 4'hF, 1'b0});

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule